// File: doc/BRIEF.md
# Comparator event interrupt controller

This block turns a one-bit comparator output, already synchronised to the local clock, into an interrupt. Software picks which comparator behaviour counts as an event: any change, a high-to-low change or a low-to-high change. One code value is kept unused and produces nothing. Each event latches a sticky flag. The flag raises an interrupt request when the block's own enable and the processor's global enable are also set. The flag clears when the interrupt controller acknowledges the vector, or when software writes a one to the flag bit.

Two side paths share the same register space. A routing bit sends the comparator output onward to a timer's input-capture logic. While the bit is clear, that output is held low. A separate register holds one disable bit per pin. A set bit forces that pin's digital readback to zero. The mode that judges an edge is the one present in that cycle. A control write that lands together with a comparator change is therefore judged by the newly written mode, so changing the mode while enabled can raise an event.

Top module: `cmp_evt_irq`

## Requirements
- R1: After reset the flag, enable, routing bit, mode and pin disable bits are all zero. The request output, the capture output and both readbacks are zero.
- R2: With mode code 2'b00, every change of the comparator output sets the flag on the following clock edge.
- R3: With mode code 2'b10, only a 1-to-0 change of the comparator output sets the flag.
- R4: With mode code 2'b11, only a 0-to-1 change of the comparator output sets the flag.
- R5: With mode code 2'b01, no comparator activity sets the flag.
- R6: A control write with data bit 0 at one clears the flag. A control write with bit 0 at zero leaves the flag as it was.
- R7: A pulse on the vector acknowledge input clears the flag.
- R8: When an event and a clear (acknowledge or write-one) arrive in the same cycle, the flag ends up set.
- R9: The interrupt request is high exactly when the flag, the enable bit and the global enable input are all high.
- R10: With the routing bit set, the capture output equals the comparator input in the same cycle. With the bit clear, the capture output stays low.
- R11: Each pin readback bit is the raw pin value, except that a set disable bit forces it to zero.
- R12: If a comparator change coincides with a control write, the mode in the written data decides whether it is an event.
- R13: The control register is selected by select value 0. Its layout is: bit 0 flag, bit 1 enable, bit 2 routing, bits 5:4 mode, other bits zero. The disable register is selected by select value 1, with pin i at bit i and the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_in | input | 1 | Synchronised comparator output |
| gie | input | 1 | Global interrupt enable |
| vec_ack | input | 1 | Interrupt controller has entered this vector |
| reg_we | input | 1 | Register write strobe |
| reg_wsel | input | 1 | Write target: 0 control, 1 pin disable |
| reg_wdata | input | 8 | Write data |
| reg_rsel | input | 1 | Read target: 0 control, 1 pin disable |
| reg_rdata | output | 8 | Read data, combinational |
| pin_raw | input | 4 | Raw digital pin values |
| pin_rd | output | 4 | Pin readback after disable gating |
| irq | output | 1 | Interrupt request |
| cap_out | output | 1 | Comparator output routed to timer capture |

## Verification
The flag and both register readbacks change one clock edge after the edge that samples the stimulus. The request, the capture output and the pin readback follow their inputs within the same cycle, because they are combinational. The bench drives every input on the falling clock edge. It then checks registered results at the next falling edge, one full rising edge later. It checks combinational results a moment after driving them, inside the same low phase. Every vector first moves the comparator to its starting level and clears the flag. Only then is the change under test applied, so each check sees exactly one edge.

// File: rtl/cmp_evt_pkg.sv
package cmp_evt_pkg;

  typedef enum logic [1:0] {
    MODE_TOGGLE = 2'b00,
    MODE_RSVD   = 2'b01,
    MODE_FALL   = 2'b10,
    MODE_RISE   = 2'b11
  } cev_mode_e;

  localparam int unsigned CTRL_FLAG_BIT  = 0;
  localparam int unsigned CTRL_IEN_BIT   = 1;
  localparam int unsigned CTRL_ROUTE_BIT = 2;
  localparam int unsigned CTRL_MODE_LSB  = 4;
  localparam int unsigned CTRL_MODE_MSB  = 5;

  // Decide whether a previous/current pair is an event in the given mode.
  function automatic logic evt_hit(cev_mode_e m, logic prev_v, logic cur_v);
    case (m)
      MODE_TOGGLE: return prev_v ^ cur_v;
      MODE_FALL:   return prev_v & ~cur_v;
      MODE_RISE:   return ~prev_v & cur_v;
      default:     return 1'b0;
    endcase
  endfunction

  // Next value of the sticky flag: a set outranks any clear.
  function automatic logic flag_next(logic cur, logic set_i, logic clr_i);
    if (set_i)      return 1'b1;
    else if (clr_i) return 1'b0;
    else            return cur;
  endfunction

endpackage

// File: rtl/cev_edge_detect.sv
module cev_edge_detect
  import cmp_evt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmp_in,
  input  cev_mode_e mode_eff,
  output logic      prev_q,
  output logic      evt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cmp_in;
  end

  assign evt = evt_hit(mode_eff, prev_q, cmp_in);

  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MODE_RSVD) |-> !evt);
  a_r3_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_eff == MODE_FALL) |-> (prev_q && !cmp_in));
  a_r4_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && mode_eff == MODE_RISE) |-> (!prev_q && cmp_in));
  a_r2_toggle_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_eff == MODE_TOGGLE && (cmp_in != prev_q)) |-> evt);

endmodule

// File: rtl/cev_ctrl_regs.sv
module cev_ctrl_regs
  import cmp_evt_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic            wsel,
  input  logic [DW-1:0]   wdata,
  input  logic            rsel,
  input  logic            evt,
  input  logic            vec_ack,
  output cev_mode_e       mode_eff,
  output logic            flag,
  output logic            ien,
  output logic            route,
  output logic [NPIN-1:0] pin_dis,
  output logic [DW-1:0]   rdata
);

  cev_mode_e mode_q;
  logic      ctrl_wr;
  logic      dis_wr;
  logic      sw_clr;
  logic      flag_clr;
  logic      unused_wbits;

  assign ctrl_wr  = we && !wsel;
  assign dis_wr   = we && wsel;
  assign sw_clr   = ctrl_wr && wdata[CTRL_FLAG_BIT];
  assign flag_clr = sw_clr || vec_ack;

  // A mode being written this cycle already judges this cycle's edge.
  assign mode_eff = ctrl_wr ? cev_mode_e'(wdata[CTRL_MODE_MSB:CTRL_MODE_LSB]) : mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      ien    <= 1'b0;
      route  <= 1'b0;
      mode_q <= MODE_TOGGLE;
    end else begin
      flag <= flag_next(flag, evt, flag_clr);
      if (ctrl_wr) begin
        ien    <= wdata[CTRL_IEN_BIT];
        route  <= wdata[CTRL_ROUTE_BIT];
        mode_q <= cev_mode_e'(wdata[CTRL_MODE_MSB:CTRL_MODE_LSB]);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pin_dis <= '0;
    else if (dis_wr) pin_dis <= wdata[NPIN-1:0];
  end

  always_comb begin
    rdata = '0;
    if (rsel) begin
      rdata[NPIN-1:0] = pin_dis;
    end else begin
      rdata[CTRL_FLAG_BIT]                 = flag;
      rdata[CTRL_IEN_BIT]                  = ien;
      rdata[CTRL_ROUTE_BIT]                = route;
      rdata[CTRL_MODE_MSB:CTRL_MODE_LSB]   = mode_q;
    end
  end

  assign unused_wbits = ^{wdata[DW-1:CTRL_MODE_MSB+1], wdata[3]};

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> flag);
  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && vec_ack) |=> !flag);
  a_r6_w1_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt && we && !wsel && wdata[CTRL_FLAG_BIT]) |=> !flag);
  a_r6_w0_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !vec_ack && !(we && !wsel && wdata[CTRL_FLAG_BIT])) |=> flag);

endmodule

// File: rtl/cev_pin_gate.sv
module cev_pin_gate #(
  parameter int unsigned NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_raw,
  input  logic [NPIN-1:0] pin_dis,
  output logic [NPIN-1:0] pin_rd
);

  for (genvar gi = 0; gi < NPIN; gi++) begin : g_pin
    assign pin_rd[gi] = pin_raw[gi] & ~pin_dis[gi];

    a_r11_dis_forces_zero: assert property (@(posedge clk) disable iff (!rst_n)
      pin_dis[gi] |-> !pin_rd[gi]);
  end

endmodule

// File: rtl/cmp_evt_irq.sv
module cmp_evt_irq
  import cmp_evt_pkg::*;
#(
  parameter int unsigned DW   = 8,
  parameter int unsigned NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmp_in,
  input  logic            gie,
  input  logic            vec_ack,
  input  logic            reg_we,
  input  logic            reg_wsel,
  input  logic [DW-1:0]   reg_wdata,
  input  logic            reg_rsel,
  output logic [DW-1:0]   reg_rdata,
  input  logic [NPIN-1:0] pin_raw,
  output logic [NPIN-1:0] pin_rd,
  output logic            irq,
  output logic            cap_out
);

  cev_mode_e       mode_eff;
  logic            evt;
  logic            prev_q;
  logic            flag;
  logic            ien;
  logic            route;
  logic [NPIN-1:0] pin_dis;

  cev_ctrl_regs #(.DW(DW), .NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .wsel(reg_wsel), .wdata(reg_wdata),
    .rsel(reg_rsel), .evt(evt), .vec_ack(vec_ack), .mode_eff(mode_eff),
    .flag(flag), .ien(ien), .route(route), .pin_dis(pin_dis), .rdata(reg_rdata)
  );

  cev_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .mode_eff(mode_eff),
    .prev_q(prev_q), .evt(evt)
  );

  cev_pin_gate #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pin_dis(pin_dis), .pin_rd(pin_rd)
  );

  assign irq     = flag & ien & gie;
  assign cap_out = route & cmp_in;

  a_r9_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> !irq);
  a_r9_ien_gates: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata[CTRL_IEN_BIT] == 1'b0 && !reg_rsel) |-> !irq);
  a_r10_cap_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    !route |-> !cap_out);
  a_r10_cap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    route |-> (cap_out == cmp_in));

endmodule

// File: tb/cmp_evt_irq_test.sv
`timescale 1ns/1ps
module cmp_evt_irq_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_in = 1'b0;
  logic       gie = 1'b0;
  logic       vec_ack = 1'b0;
  logic       reg_we = 1'b0;
  logic       reg_wsel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic       reg_rsel = 1'b0;
  logic [7:0] reg_rdata;
  logic [3:0] pin_raw = 4'h0;
  logic [3:0] pin_rd;
  logic       irq;
  logic       cap_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmp_evt_irq uut (
    .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .gie(gie), .vec_ack(vec_ack),
    .reg_we(reg_we), .reg_wsel(reg_wsel), .reg_wdata(reg_wdata),
    .reg_rsel(reg_rsel), .reg_rdata(reg_rdata), .pin_raw(pin_raw),
    .pin_rd(pin_rd), .irq(irq), .cap_out(cap_out)
  );

  // {mode[1:0], prev, cur, expected flag}
  localparam logic [4:0] VEC [16] = '{
    5'b00_00_0, 5'b00_01_1, 5'b00_10_1, 5'b00_11_0,
    5'b01_00_0, 5'b01_01_0, 5'b01_10_0, 5'b01_11_0,
    5'b10_00_0, 5'b10_01_0, 5'b10_10_1, 5'b10_11_0,
    5'b11_00_0, 5'b11_01_1, 5'b11_10_0, 5'b11_11_0
  };

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] ctrl_word(logic [1:0] m, logic en, logic rt, logic clr);
    return {2'b00, m, 1'b0, rt, en, clr};
  endfunction

  task automatic wr(logic sel, logic [7:0] d);
    reg_we = 1'b1; reg_wsel = sel; reg_wdata = d;
    step();
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00: return "R2 toggle";
      2'b01: return "R5 reserved";
      2'b10: return "R3 falling";
      default: return "R4 rising";
    endcase
  endfunction

  initial begin
    #(8 * 200000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    // R1: reset state
    chk("R1 ctrl readback", reg_rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 cap_out", {7'd0, cap_out}, 8'h00);
    rst_n = 1'b1;
    step();
    chk("R1 ctrl after release", reg_rdata, 8'h00);
    reg_rsel = 1'b1; #1;
    chk("R1 disable readback", reg_rdata, 8'h00);
    reg_rsel = 1'b0;
    gie = 1'b1;

    // Vector table: R2, R3, R4, R5, R9
    for (int i = 0; i < 16; i++) begin
      logic [1:0] m;
      m = VEC[i][4:3];
      cmp_in = VEC[i][2];
      step();
      wr(1'b0, ctrl_word(m, 1'b1, 1'b0, 1'b1));
      cmp_in = VEC[i][1];
      step();
      chk(mode_tag(m), {7'd0, reg_rdata[0]}, {7'd0, VEC[i][0]});
      chk("R9 irq follows flag", {7'd0, irq}, {7'd0, VEC[i][0]});
    end

    // R13: control layout, mode 11, enable and routing set
    cmp_in = 1'b0;
    wr(1'b0, ctrl_word(2'b11, 1'b1, 1'b1, 1'b1));
    chk("R13 ctrl layout", reg_rdata, 8'h36);

    // R10: routing on
    cmp_in = 1'b1; #1;
    chk("R10 cap follows high", {7'd0, cap_out}, 8'h01);
    step(); // rising edge in mode 11 sets flag
    cmp_in = 1'b0; #1;
    chk("R10 cap follows low", {7'd0, cap_out}, 8'h00);
    step();

    // R6: write zero keeps the flag, write one clears it
    chk("R6 flag set before", {7'd0, reg_rdata[0]}, 8'h01);
    wr(1'b0, ctrl_word(2'b11, 1'b1, 1'b0, 1'b0));
    chk("R6 write zero keeps", {7'd0, reg_rdata[0]}, 8'h01);
    // R9: gating by global and local enable
    gie = 1'b0; #1;
    chk("R9 gie low", {7'd0, irq}, 8'h00);
    gie = 1'b1; #1;
    chk("R9 all high", {7'd0, irq}, 8'h01);
    // R10: routing off
    cmp_in = 1'b1; #1;
    chk("R10 cap blocked", {7'd0, cap_out}, 8'h00);
    step();
    cmp_in = 1'b0;
    step();
    wr(1'b0, ctrl_word(2'b11, 1'b0, 1'b0, 1'b0));
    chk("R9 ien low", {7'd0, irq}, 8'h00);
    wr(1'b0, ctrl_word(2'b11, 1'b1, 1'b0, 1'b1));
    chk("R6 write one clears", {7'd0, reg_rdata[0]}, 8'h00);

    // R7 and R8: acknowledge versus event
    cmp_in = 1'b1; vec_ack = 1'b1;
    step();
    vec_ack = 1'b0;
    chk("R8 event beats ack", {7'd0, reg_rdata[0]}, 8'h01);
    vec_ack = 1'b1;
    step();
    vec_ack = 1'b0;
    chk("R7 ack clears", {7'd0, reg_rdata[0]}, 8'h00);
    cmp_in = 1'b0;
    step();
    cmp_in = 1'b1;
    wr(1'b0, ctrl_word(2'b11, 1'b1, 1'b0, 1'b1));
    chk("R8 event beats write-one", {7'd0, reg_rdata[0]}, 8'h01);

    // R12: mode written together with an edge judges that edge
    wr(1'b0, ctrl_word(2'b11, 1'b1, 1'b0, 1'b1));
    chk("R12 setup clear", {7'd0, reg_rdata[0]}, 8'h00);
    cmp_in = 1'b0;
    wr(1'b0, ctrl_word(2'b10, 1'b1, 1'b0, 1'b0));
    chk("R12 falling under new mode", {7'd0, reg_rdata[0]}, 8'h01);
    wr(1'b0, ctrl_word(2'b10, 1'b1, 1'b0, 1'b1));
    cmp_in = 1'b1;
    wr(1'b0, ctrl_word(2'b10, 1'b1, 1'b0, 1'b0));
    chk("R12 rising ignored by new falling mode", {7'd0, reg_rdata[0]}, 8'h00);
    cmp_in = 1'b0;
    wr(1'b0, ctrl_word(2'b01, 1'b1, 1'b0, 1'b0));
    chk("R12 falling ignored by new reserved mode", {7'd0, reg_rdata[0]}, 8'h00);

    // R11 and R13: pin disable
    pin_raw = 4'hF;
    wr(1'b1, 8'h05);
    chk("R11 gated pins", {4'd0, pin_rd}, 8'h0A);
    pin_raw = 4'h6; #1;
    chk("R11 raw pattern", {4'd0, pin_rd}, 8'h02);
    reg_rsel = 1'b1; #1;
    chk("R13 disable readback", reg_rdata, 8'h05);
    reg_rsel = 1'b0;
    wr(1'b1, 8'h00);
    chk("R11 all enabled", {4'd0, pin_rd}, 8'h06);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule